// File: doc/BRIEF.md
# Embedded Flash Page Program Controller

This block drives a small on-chip flash array from a byte-wide register bus. Software selects a location through a two-byte address register, places a byte in a data register, and issues one-byte commands. Programming is staged: the 128-byte page buffer is first cleared, then filled one byte at a time, each byte placed by an address write plus a load command, and only afterwards is the whole buffer committed to the page the address selects by a separate program command. Page erase and whole-array erase are also provided, as is a read of a fixed trim row, and a read of any array byte back into the data register.

Program and erase take a configurable number of clock cycles. For their duration the ready flag in the status register is low. It returns high exactly when the array has been updated. A command written while the controller is busy is discarded and raises a sticky error flag. The array model keeps programming one-directional: a programmed byte becomes the old content AND the buffer byte, and only erase brings bits back to 1.

Register offsets on `bus_addr`: 0 status, 1 command, 2 data, 3 address low byte, 4 address high byte. The byte address is {high, low}; bits 6:0 select the byte within a page and the bits above select the page.

Top module: `eflash_ctrl`

## Requirements
- R1: After reset the status register reads 0x80, the data and address registers read 0x00, and every array byte reads 0xFF.
- R2: Writes to the data register (offset 2) and to the address low and high bytes (offsets 3 and 4) are read back unchanged on the next read of the same offset.
- R3: Command 0x80 sets all 128 page-buffer bytes to 0xFF, so a following program changes only the bytes loaded after the clear.
- R4: Command 0x02 copies the data register into page-buffer byte number address[6:0].
- R5: Command 0x70 replaces every byte of the page selected by address[ADDR_W-1:7] with the old byte AND the matching buffer byte.
- R6: Command 0x20 sets every byte of the selected page to 0xFF and leaves the other pages unchanged.
- R7: Command 0x60 sets every byte of the array to 0xFF.
- R8: Command 0x90 loads the data register with the trim-row byte at offset k = address[6:0], whose value is (TRIM_SEED + 3*k) mod 256 (TRIM_SEED defaults to 0xA5).
- R9: Command 0x0B loads the data register with the array byte at the current address.
- R10: Status bit 7 (ready) is 0 in each of the PROG_CYC (for 0x70) or ERASE_CYC (for 0x20 and 0x60) cycles that follow the cycle in which the command is written, and it is 1 from the next cycle on.
- R11: A command written while ready is 0 has no effect and sets status bit 1 (error); the error stays set until a status write with bit 1 equal to 1.
- R12: A command code other than those above changes no register, buffer or array byte, and leaves status at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at bus_addr, combinational |

## Verification
Programming is tried with a fresh page, with a second program of the same page over existing data, and with a buffer that was partly loaded and then cleared; these separate a true AND with the old content from an overwrite, and a cleared buffer from stale buffer bytes. Erase is tried on one page beside a programmed neighbour and on the whole array, which tells page decoding apart from a global erase. The ready flag is sampled on the last busy cycle and the first ready cycle, so an off-by-one duration shows. A command issued during an erase, an unknown code and trim reads at several offsets, with high address bits set, show that rejected commands leave state intact and that trim indexing uses only the in-page bits.

// File: rtl/eflash_pkg.sv
package eflash_pkg;

    localparam int PAGE_BYTES = 128;
    localparam int IDX_W      = 7;

    localparam logic [2:0] REG_STAT = 3'd0;
    localparam logic [2:0] REG_CMD  = 3'd1;
    localparam logic [2:0] REG_DATA = 3'd2;
    localparam logic [2:0] REG_ALO  = 3'd3;
    localparam logic [2:0] REG_AHI  = 3'd4;

    localparam logic [7:0] CMD_LOAD     = 8'h02;
    localparam logic [7:0] CMD_READ     = 8'h0B;
    localparam logic [7:0] CMD_ERASE_PG = 8'h20;
    localparam logic [7:0] CMD_ERASE_AL = 8'h60;
    localparam logic [7:0] CMD_PROG     = 8'h70;
    localparam logic [7:0] CMD_CLEAR    = 8'h80;
    localparam logic [7:0] CMD_TRIM     = 8'h90;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERPG,
        OP_ERAL
    } op_e;

    function automatic logic [7:0] trim_value(input logic [7:0] seed,
                                              input logic [IDX_W-1:0] idx);
        logic [7:0] k;
        k = {1'b0, idx};
        return seed + (k + k + k);
    endfunction

endpackage

// File: rtl/eflash_page_buf.sv
module eflash_page_buf
    import eflash_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     ld,
    input  logic [IDX_W-1:0]         ld_idx,
    input  logic [7:0]               ld_data,
    output logic [PAGE_BYTES*8-1:0]  buf_flat
);

    logic [7:0] pb_q [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pb_q[i] <= 8'hFF;
        end else if (clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) pb_q[i] <= 8'hFF;
        end else if (ld) begin
            pb_q[ld_idx] <= ld_data;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign buf_flat[g*8 +: 8] = pb_q[g];
    end

    assert_buf_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (&buf_flat));

    assert_load_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (pb_q[$past(ld_idx)] == $past(ld_data)));

endmodule

// File: rtl/eflash_array.sv
module eflash_array
    import eflash_pkg::*;
#(
    parameter int PAGE_W = 2,
    localparam int ADDR_W = PAGE_W + IDX_W,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     do_prog,
    input  logic                     do_erase_pg,
    input  logic                     do_erase_all,
    input  logic [PAGE_W-1:0]        page,
    input  logic [PAGE_BYTES*8-1:0]  buf_flat,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (do_erase_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (do_erase_pg) begin
            for (int j = 0; j < PAGE_BYTES; j++) mem[{page, IDX_W'(j)}] <= 8'hFF;
        end else if (do_prog) begin
            for (int j = 0; j < PAGE_BYTES; j++)
                mem[{page, IDX_W'(j)}] <= mem[{page, IDX_W'(j)}] & buf_flat[j*8 +: 8];
        end
    end

    assign rd_data = mem[rd_addr];

    assert_one_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_prog, do_erase_pg, do_erase_all}));

    assert_chip_erased_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase_all |=> (rd_data == 8'hFF));

    assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_prog && (rd_addr[ADDR_W-1:IDX_W] == page)) |=>
            ((rd_data & ~$past(rd_data)) == 8'h00 || rd_addr != $past(rd_addr)));

endmodule

// File: rtl/eflash_ctrl.sv
module eflash_ctrl
    import eflash_pkg::*;
#(
    parameter int          PAGE_W    = 2,
    parameter int          PROG_CYC  = 20,
    parameter int          ERASE_CYC = 30,
    parameter logic [7:0]  TRIM_SEED = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int ADDR_W  = PAGE_W + IDX_W;
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic              err;
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic [7:0]        data;
        logic [15:0]       addr;
    } ctl_s;

    ctl_s q, d;

    logic                    fire;
    logic                    buf_clr, buf_ld;
    logic [PAGE_BYTES*8-1:0] buf_flat;
    logic [7:0]              arr_rd;

    always_comb begin
        d       = q;
        fire    = q.busy && (q.cnt == '0);
        buf_clr = 1'b0;
        buf_ld  = 1'b0;

        if (q.busy) begin
            if (fire) begin
                d.busy = 1'b0;
                d.op   = OP_NONE;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end

        if (bus_we) begin
            case (bus_addr)
                REG_STAT: if (bus_wdata[1]) d.err = 1'b0;
                REG_DATA: d.data = bus_wdata;
                REG_ALO:  d.addr[7:0] = bus_wdata;
                REG_AHI:  d.addr[15:8] = bus_wdata;
                REG_CMD: begin
                    if (q.busy) begin
                        d.err = 1'b1;
                    end else begin
                        case (bus_wdata)
                            CMD_LOAD:  buf_ld = 1'b1;
                            CMD_CLEAR: buf_clr = 1'b1;
                            CMD_READ:  d.data = arr_rd;
                            CMD_TRIM:  d.data = trim_value(TRIM_SEED, q.addr[IDX_W-1:0]);
                            CMD_PROG: begin
                                d.busy = 1'b1;
                                d.op   = OP_PROG;
                                d.cnt  = CNT_W'(PROG_CYC - 1);
                                d.page = q.addr[ADDR_W-1:IDX_W];
                            end
                            CMD_ERASE_PG: begin
                                d.busy = 1'b1;
                                d.op   = OP_ERPG;
                                d.cnt  = CNT_W'(ERASE_CYC - 1);
                                d.page = q.addr[ADDR_W-1:IDX_W];
                            end
                            CMD_ERASE_AL: begin
                                d.busy = 1'b1;
                                d.op   = OP_ERAL;
                                d.cnt  = CNT_W'(ERASE_CYC - 1);
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, err: 1'b0, op: OP_NONE, cnt: '0, page: '0,
                   data: 8'h00, addr: 16'h0000};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_STAT: bus_rdata = {~q.busy, 5'b00000, q.err, 1'b0};
            REG_DATA: bus_rdata = q.data;
            REG_ALO:  bus_rdata = q.addr[7:0];
            REG_AHI:  bus_rdata = q.addr[15:8];
            default:  bus_rdata = 8'h00;
        endcase
    end

    eflash_page_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .ld       (buf_ld),
        .ld_idx   (q.addr[IDX_W-1:0]),
        .ld_data  (q.data),
        .buf_flat (buf_flat)
    );

    eflash_array #(.PAGE_W(PAGE_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_prog      (fire && (q.op == OP_PROG)),
        .do_erase_pg  (fire && (q.op == OP_ERPG)),
        .do_erase_all (fire && (q.op == OP_ERAL)),
        .page         (q.page),
        .buf_flat     (buf_flat),
        .rd_addr      (q.addr[ADDR_W-1:0]),
        .rd_data      (arr_rd)
    );

    assert_busy_cmd_errs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_CMD && q.busy) |=> q.err);

    assert_busy_from_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(bus_we && bus_addr == REG_CMD));

    assert_done_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> ($past(q.cnt) == '0));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.err) |-> $past(bus_we && bus_addr == REG_STAT && bus_wdata[1]));

endmodule

// File: tb/eflash_ctrl_tb_top.sv
`timescale 1ns/1ps
module eflash_ctrl_tb_top;

    localparam int PAGE_W = 2;
    localparam int PROG_CYC = 20;
    localparam int ERASE_CYC = 30;
    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] exp_mem [DEPTH];
    logic [7:0] exp_buf [128];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eflash_ctrl #(.PAGE_W(PAGE_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                  .TRIM_SEED(8'hA5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr(3'd3, a[7:0]);
        wr(3'd4, a[15:8]);
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 200; i++) begin
            rd(3'd0, s);
            if (s[7]) return;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [15:0] a, output logic [7:0] v);
        set_addr(a);
        wr(3'd1, 8'h0B);
        rd(3'd2, v);
    endtask

    task automatic load_byte(input logic [6:0] idx, input logic [7:0] v, input logic [15:0] base);
        set_addr(base | 16'(idx));
        wr(3'd2, v);
        wr(3'd1, 8'h02);
        exp_buf[idx] = v;
    endtask

    task automatic clear_buf();
        wr(3'd1, 8'h80);
        for (int i = 0; i < 128; i++) exp_buf[i] = 8'hFF;
    endtask

    task automatic program_page(input int pg);
        set_addr(16'(pg * 128));
        wr(3'd1, 8'h70);
        wait_ready();
        for (int i = 0; i < 128; i++) exp_mem[pg*128+i] = exp_mem[pg*128+i] & exp_buf[i];
    endtask

    task automatic test_reset();
        logic [7:0] v;
        rd(3'd0, v); check("R1 status", v, 8'h80);
        rd(3'd2, v); check("R1 data", v, 8'h00);
        rd(3'd3, v); check("R1 addr lo", v, 8'h00);
        rd(3'd4, v); check("R1 addr hi", v, 8'h00);
        read_byte(16'h0000, v); check("R1 array byte 0", v, 8'hFF);
        read_byte(16'h01FF, v); check("R1 array last byte", v, 8'hFF);
    endtask

    task automatic test_regs();
        logic [7:0] v;
        wr(3'd2, 8'h5A); rd(3'd2, v); check("R2 data", v, 8'h5A);
        wr(3'd3, 8'hC3); rd(3'd3, v); check("R2 addr lo", v, 8'hC3);
        wr(3'd4, 8'h7E); rd(3'd4, v); check("R2 addr hi", v, 8'h7E);
    endtask

    task automatic test_program_timing();
        logic [7:0] v;
        clear_buf();
        load_byte(7'd0, 8'h12, 16'h0080);
        load_byte(7'd5, 8'hA7, 16'h0080);
        load_byte(7'd127, 8'h3C, 16'h0080);
        set_addr(16'h0080);
        wr(3'd1, 8'h70);
        rd(3'd0, v); check("R10 prog busy first", v, 8'h00);
        repeat (PROG_CYC - 1) @(negedge clk);
        rd(3'd0, v); check("R10 prog busy last", v, 8'h00);
        @(negedge clk);
        rd(3'd0, v); check("R10 prog ready", v, 8'h80);
        for (int i = 0; i < 128; i++) exp_mem[128+i] = exp_mem[128+i] & exp_buf[i];
        read_byte(16'h0080, v); check("R5 R4 byte 0", v, exp_mem[128]);
        read_byte(16'h0085, v); check("R5 R4 byte 5", v, exp_mem[133]);
        read_byte(16'h00FF, v); check("R5 R4 byte 127", v, exp_mem[255]);
        read_byte(16'h0086, v); check("R5 unloaded byte", v, 8'hFF);
        read_byte(16'h0005, v); check("R5 other page", v, 8'hFF);
    endtask

    task automatic test_and_program();
        logic [7:0] v;
        clear_buf();
        load_byte(7'd5, 8'h5F, 16'h0080);
        program_page(1);
        read_byte(16'h0085, v); check("R5 AND with old", v, 8'h07);
        read_byte(16'h0080, v); check("R5 untouched byte", v, 8'h12);
    endtask

    task automatic test_clear();
        logic [7:0] v;
        load_byte(7'd10, 8'h00, 16'h0100);
        load_byte(7'd11, 8'h00, 16'h0100);
        clear_buf();
        load_byte(7'd12, 8'h81, 16'h0100);
        program_page(2);
        read_byte(16'h010A, v); check("R3 cleared byte 10", v, 8'hFF);
        read_byte(16'h010B, v); check("R3 cleared byte 11", v, 8'hFF);
        read_byte(16'h010C, v); check("R3 loaded after clear", v, 8'h81);
    endtask

    task automatic test_erase_page();
        logic [7:0] v;
        set_addr(16'h00C0);
        wr(3'd1, 8'h20);
        repeat (ERASE_CYC - 1) @(negedge clk);
        rd(3'd0, v); check("R10 erase busy last", v, 8'h00);
        @(negedge clk);
        rd(3'd0, v); check("R10 erase ready", v, 8'h80);
        for (int i = 0; i < 128; i++) exp_mem[128+i] = 8'hFF;
        read_byte(16'h0080, v); check("R6 erased byte 0", v, 8'hFF);
        read_byte(16'h0085, v); check("R6 erased byte 5", v, 8'hFF);
        read_byte(16'h010C, v); check("R6 neighbour kept", v, 8'h81);
    endtask

    task automatic test_busy_error();
        logic [7:0] v;
        set_addr(16'h0000);
        wr(3'd1, 8'h20);
        wr(3'd1, 8'h60);
        rd(3'd0, v); check("R11 busy with error", v, 8'h02);
        wait_ready();
        rd(3'd0, v); check("R11 error sticky", v, 8'h82);
        read_byte(16'h010C, v); check("R11 ignored chip erase", v, 8'h81);
        wr(3'd0, 8'h02);
        rd(3'd0, v); check("R11 error cleared", v, 8'h80);
    endtask

    task automatic test_unknown();
        logic [7:0] v;
        set_addr(16'h010C);
        wr(3'd2, 8'h3C);
        wr(3'd1, 8'h55);
        rd(3'd0, v); check("R12 status", v, 8'h80);
        rd(3'd2, v); check("R12 data kept", v, 8'h3C);
        rd(3'd3, v); check("R12 addr kept", v, 8'h0C);
        read_byte(16'h010C, v); check("R12 array kept", v, 8'h81);
    endtask

    task automatic test_trim();
        logic [7:0] v;
        int offs [4] = '{0, 1, 77, 127};
        for (int i = 0; i < 4; i++) begin
            set_addr(16'h0100 | 16'(offs[i]));
            wr(3'd1, 8'h90);
            rd(3'd2, v);
            check("R8 trim", v, 8'((8'hA5 + 3 * offs[i]) & 255));
        end
    endtask

    task automatic test_chip_erase();
        logic [7:0] v;
        wr(3'd1, 8'h60);
        wait_ready();
        read_byte(16'h010C, v); check("R7 page 2 erased", v, 8'hFF);
        read_byte(16'h01FF, v); check("R7 last byte", v, 8'hFF);
        read_byte(16'h0000, v); check("R7 first byte", v, 8'hFF);
    endtask

    task automatic read_check_r9();
        logic [7:0] v;
        clear_buf();
        load_byte(7'd99, 8'h4B, 16'h0180);
        program_page(3);
        read_byte(16'h01E3, v); check("R9 read array", v, 8'h4B);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < 128; i++) exp_buf[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regs();
        test_program_timing();
        test_and_program();
        test_clear();
        test_erase_page();
        test_busy_error();
        test_unknown();
        test_trim();
        read_check_r9();
        test_chip_erase();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 100000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule